// File: doc/BRIEF.md
# SMP Interrupt Distributor

This block spreads external interrupt lines across the cores of a small multiprocessor of up to sixteen cores. It also delivers software-generated inter-processor interrupts (IPIs). Software reaches it through a plain register port that has an address, write data, a write strobe and registered read data. Each external line has its own routing mask that names the cores it may interrupt. A global enable vector gates every line. Each core gets one level-style external interrupt output.

Each core has sixteen IPI cause bits. Any core can set a chosen cause bit in a set of target cores through a set window. The target core acknowledges by writing ones to its own cause register. The OR of a core's cause bits drives that core's IPI output.

The block also holds a few control registers: an 8-bit IPI partition value, a read-only configuration word, a per-core run-stall mask and a single coherency-enable bit.

Top module: `smp_irq_distributor`

## Requirements
- R1: `ext_irq[c]` is high one clock after an edge at which some line n has `irq_lines[n]` high, its enable bit set and bit c of its routing mask set. Otherwise it is low one clock later.
- R2: The routing mask of line n is read and written at address n (low NUM_CORES bits). Each mask resets to 1, which routes to core 0.
- R3: A write to 0x180 clears the enable bits where the data is 1. A write to 0x184 sets them. A read of either address returns the enable vector.
- R4: `ipi_irq[c]` is the OR of the 16 cause bits of core c. Those bits read back at 0x100 + c.
- R5: A write to 0x140 + k (k = 0..15) sets cause bit k in every core c whose bit c in the write data is 1. Reads of this window return 0.
- R6: A write to 0x100 + c clears the cause bits of core c where the data is 1 and leaves the other bits unchanged.
- R7: A write to 0x18C ORs the data into the global assert register, which reads at 0x188. A write to 0x188 has no effect, and a read of 0x18C returns 0.
- R8: 0x190 is an 8-bit read/write partition register that resets to 0.
- R9: 0x1A0 reads {RELEASE[9:0], NUM_CORES-1 in 4 bits, DEVICE_ID[17:0]}, most significant field first, and ignores writes.
- R10: 0x200 holds the run-stall mask, driven on `run_stall`, which resets to every core stalled except core 0. Bit 0 of 0x220 is `coherency_en`, which resets to 0.
- R11: Read data appears one clock after the address. Addresses that are not mapped, including route and cause slots beyond the configured counts, read 0.
- R12: After reset every enable bit, every cause bit and the global assert register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Level external interrupt lines |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Registered read data |
| ext_irq | output | NUM_CORES | Per-core external interrupt |
| ipi_irq | output | NUM_CORES | Per-core inter-processor interrupt |
| run_stall | output | NUM_CORES | Per-core stall control |
| coherency_en | output | 1 | Coherency enable |

## Verification
A wrong routing mask or enable bit shows on `ext_irq` one clock after the first edge at which the affected line is active. It can stay hidden for a long time if that line is quiet, so the bench drives random line levels alongside the register traffic. A corrupt cause bit shows on `ipi_irq` in the cycle after the faulty write. A register that holds a bad value shows on `reg_rdata` one clock after its address is presented. Because of this, the reference model is compared with every output on every clock.

// File: rtl/smp_irq_distributor.sv
module smp_irq_distributor #(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int ADDR_W = 10,
  parameter logic [9:0] RELEASE = 10'h1C3,
  parameter logic [17:0] DEVICE_ID = 18'h20A5F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_we,
  output logic [31:0]          reg_rdata,
  output logic [NUM_CORES-1:0] ext_irq,
  output logic [NUM_CORES-1:0] ipi_irq,
  output logic [NUM_CORES-1:0] run_stall,
  output logic                 coherency_en
);
  localparam int CAUSES = 16;
  localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'('h140);
  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'('h180);
  localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'('h184);
  localparam logic [ADDR_W-1:0] A_GA     = ADDR_W'('h188);
  localparam logic [ADDR_W-1:0] A_GA_SET = ADDR_W'('h18C);
  localparam logic [ADDR_W-1:0] A_PART   = ADDR_W'('h190);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'('h1A0);
  localparam logic [ADDR_W-1:0] A_STALL  = ADDR_W'('h200);
  localparam logic [ADDR_W-1:0] A_COH    = ADDR_W'('h220);
  localparam logic [31:0] CFG_WORD = {RELEASE, 4'(NUM_CORES - 1), DEVICE_ID};
  localparam logic [NUM_CORES-1:0] STALL_RST = ~NUM_CORES'(1);

  logic [NUM_CORES-1:0] route_q [NUM_LINES];
  logic [CAUSES-1:0]    cause_q [NUM_CORES];
  logic [NUM_LINES-1:0] enable_q, gassert_q;
  logic [7:0]           part_q;
  logic [NUM_CORES-1:0] stall_q, ext_next;
  logic                 coh_q;
  logic [31:0]          rd_next;

  wire       set_hit = (reg_addr >= A_SET) && (reg_addr < A_SET + ADDR_W'(CAUSES));
  wire [3:0] set_idx = reg_addr[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_LINES; n++) route_q[n] <= NUM_CORES'(1);
      for (int c = 0; c < NUM_CORES; c++) cause_q[c] <= '0;
      enable_q  <= '0;
      gassert_q <= '0;
      part_q    <= '0;
      stall_q   <= STALL_RST;
      coh_q     <= 1'b0;
    end else if (reg_we) begin
      for (int n = 0; n < NUM_LINES; n++)
        if (reg_addr == ADDR_W'(n)) route_q[n] <= reg_wdata[NUM_CORES-1:0];
      for (int c = 0; c < NUM_CORES; c++) begin
        if (reg_addr == A_CAUSE + ADDR_W'(c))
          cause_q[c] <= cause_q[c] & ~reg_wdata[CAUSES-1:0];
        else if (set_hit && reg_wdata[c])
          cause_q[c][set_idx] <= 1'b1;
      end
      if (reg_addr == A_EN_CLR) enable_q <= enable_q & ~reg_wdata[NUM_LINES-1:0];
      if (reg_addr == A_EN_SET) enable_q <= enable_q | reg_wdata[NUM_LINES-1:0];
      if (reg_addr == A_GA_SET) gassert_q <= gassert_q | reg_wdata[NUM_LINES-1:0];
      if (reg_addr == A_PART)   part_q <= reg_wdata[7:0];
      if (reg_addr == A_STALL)  stall_q <= reg_wdata[NUM_CORES-1:0];
      if (reg_addr == A_COH)    coh_q <= reg_wdata[0];
    end
  end

  always_comb begin
    ext_next = '0;
    for (int c = 0; c < NUM_CORES; c++)
      for (int n = 0; n < NUM_LINES; n++)
        ext_next[c] = ext_next[c] | (irq_lines[n] & enable_q[n] & route_q[n][c]);
  end

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) ipi_irq[c] = |cause_q[c];
  end

  always_comb begin
    rd_next = '0;
    for (int n = 0; n < NUM_LINES; n++)
      if (reg_addr == ADDR_W'(n)) rd_next = 32'(route_q[n]);
    for (int c = 0; c < NUM_CORES; c++)
      if (reg_addr == A_CAUSE + ADDR_W'(c)) rd_next = 32'(cause_q[c]);
    if (reg_addr == A_EN_CLR || reg_addr == A_EN_SET) rd_next = 32'(enable_q);
    if (reg_addr == A_GA)    rd_next = 32'(gassert_q);
    if (reg_addr == A_PART)  rd_next = 32'(part_q);
    if (reg_addr == A_CFG)   rd_next = CFG_WORD;
    if (reg_addr == A_STALL) rd_next = 32'(stall_q);
    if (reg_addr == A_COH)   rd_next = 32'(coh_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      ext_irq   <= '0;
    end else begin
      reg_rdata <= rd_next;
      ext_irq   <= ext_next;
    end
  end

  assign run_stall    = stall_q;
  assign coherency_en = coh_q;
endmodule

// File: rtl/smp_irq_distributor_chk.sv
module smp_irq_distributor_chk #(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int ADDR_W = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [31:0]          reg_wdata,
  input logic                 reg_we,
  input logic [31:0]          reg_rdata,
  input logic [NUM_CORES-1:0] ext_irq,
  input logic [NUM_CORES-1:0] ipi_irq,
  input logic                 coherency_en
);
  p_ext_needs_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq != '0) |-> ($past(irq_lines) != '0));

  p_ipi_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr >= ADDR_W'('h140) && reg_addr < ADDR_W'('h150))
    |=> ((ipi_irq & $past(reg_wdata[NUM_CORES-1:0])) == $past(reg_wdata[NUM_CORES-1:0])));

  p_cfg_cores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'('h1A0)) |=> (reg_rdata[21:18] == 4'(NUM_CORES - 1)));

  p_coh_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == ADDR_W'('h220)) |=> $stable(coherency_en));

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= ADDR_W'('h240)) |=> (reg_rdata == '0));
endmodule

bind smp_irq_distributor smp_irq_distributor_chk #(
  .NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
  .ext_irq(ext_irq), .ipi_irq(ipi_irq), .coherency_en(coherency_en)
);

// File: tb/smp_irq_distributor_tb_top.sv
`timescale 1ns/1ps
module smp_irq_distributor_tb_top;
  localparam int NC = 4;
  localparam int NL = 8;
  localparam logic [31:0] CFG = {10'h1C3, 4'd3, 18'h20A5F};

  logic clk = 0;
  logic rst_n = 0;
  logic [NL-1:0] irq_lines = '0;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic reg_we = 0;
  logic [31:0] reg_rdata;
  logic [NC-1:0] ext_irq, ipi_irq, run_stall;
  logic coherency_en;

  int checks = 0, failures = 0;
  bit started = 0, done = 0;

  always #5 clk = ~clk;

  smp_irq_distributor dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .ext_irq(ext_irq), .ipi_irq(ipi_irq), .run_stall(run_stall),
    .coherency_en(coherency_en)
  );

  bit [NC-1:0] m_route [NL];
  bit [15:0]   m_cause [NC];
  bit [NL-1:0] m_en, m_ga;
  bit [7:0]    m_part;
  bit [NC-1:0] m_stall, m_ext;
  bit          m_coh;
  bit [31:0]   m_rdata;

  function automatic bit [31:0] model_read(int a);
    if (a < NL) return 32'(m_route[a]);
    if (a >= 'h100 && a < 'h100 + NC) return 32'(m_cause[a - 'h100]);
    if (a == 'h180 || a == 'h184) return 32'(m_en);
    if (a == 'h188) return 32'(m_ga);
    if (a == 'h190) return 32'(m_part);
    if (a == 'h1A0) return CFG;
    if (a == 'h200) return 32'(m_stall);
    if (a == 'h220) return 32'(m_coh);
    return 0;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      for (int n = 0; n < NL; n++) m_route[n] = 1;
      for (int c = 0; c < NC; c++) m_cause[c] = 0;
      m_en = 0; m_ga = 0; m_part = 0; m_stall = 4'b1110; m_coh = 0;
      m_ext = 0; m_rdata = 0;
    end else begin
      int a;
      a = int'(reg_addr);
      m_ext = 0;
      for (int n = 0; n < NL; n++)
        if (irq_lines[n] && m_en[n]) m_ext = m_ext | m_route[n];
      m_rdata = model_read(a);
      if (reg_we) begin
        if (a < NL) m_route[a] = reg_wdata[NC-1:0];
        if (a >= 'h100 && a < 'h100 + NC) m_cause[a - 'h100] &= ~reg_wdata[15:0];
        if (a >= 'h140 && a < 'h150)
          for (int c = 0; c < NC; c++) if (reg_wdata[c]) m_cause[c][a - 'h140] = 1'b1;
        if (a == 'h180) m_en &= ~reg_wdata[NL-1:0];
        if (a == 'h184) m_en |= reg_wdata[NL-1:0];
        if (a == 'h18C) m_ga |= reg_wdata[NL-1:0];
        if (a == 'h190) m_part = reg_wdata[7:0];
        if (a == 'h200) m_stall = reg_wdata[NC-1:0];
        if (a == 'h220) m_coh = reg_wdata[0];
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      bit [NC-1:0] m_ipi;
      for (int c = 0; c < NC; c++) m_ipi[c] = |m_cause[c];
      check("R11 rdata vs model", reg_rdata, m_rdata);
      check("R1 ext_irq vs model", 32'(ext_irq), 32'(m_ext));
      check("R4 ipi_irq vs model", 32'(ipi_irq), 32'(m_ipi));
      check("R10 run_stall vs model", 32'(run_stall), 32'(m_stall));
      check("R10 coherency vs model", 32'(coherency_en), 32'(m_coh));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); reg_addr = 10'(a); reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string req);
    @(negedge clk); reg_addr = 10'(a); reg_we = 0;
    @(negedge clk); #1 check(req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd('h000, 1, "R2 route reset");
    rd('h200, 'hE, "R10 stall reset");
    rd('h220, 0, "R10 coherency reset");
    rd('h180, 0, "R12 enable reset");
    rd('h101, 0, "R12 cause reset");
    rd('h188, 0, "R12 global assert reset");
    rd('h1A0, CFG, "R9 config word");
    wr('h1A0, 0);
    rd('h1A0, CFG, "R9 config ignores write");
    wr('h003, 'h6);
    rd('h003, 'h6, "R2 route write");
    wr('h184, 'h0A);
    rd('h180, 'h0A, "R3 enable set");
    irq_lines = 'h08;
    @(negedge clk); @(negedge clk); #1 check("R1 line3 to cores 1,2", 32'(ext_irq), 'h6);
    irq_lines = 'h02;
    @(negedge clk); @(negedge clk); #1 check("R1 line1 to core 0", 32'(ext_irq), 'h1);
    irq_lines = 'h04;
    @(negedge clk); @(negedge clk); #1 check("R1 disabled line blocked", 32'(ext_irq), 'h0);
    wr('h180, 'h08);
    rd('h184, 'h02, "R3 enable clear");
    wr('h145, 'hA);
    rd('h101, 'h0020, "R5 set cause 5");
    #1 check("R4 ipi on cores 1,3", 32'(ipi_irq), 'hA);
    wr('h14F, 'h2);
    wr('h101, 'h0020);
    rd('h101, 'h8000, "R6 partial clear");
    rd('h140, 0, "R5 set window reads 0");
    wr('h101, 'h8000);
    wr('h103, 'hFFFF);
    @(negedge clk); #1 check("R6 all acknowledged", 32'(ipi_irq), 0);
    wr('h18C, 'h11);
    wr('h18C, 'h02);
    wr('h188, 'h00);
    rd('h188, 'h13, "R7 global assert");
    rd('h18C, 0, "R7 set address reads 0");
    wr('h190, 'h1A5);
    rd('h190, 'hA5, "R8 partition");
    wr('h200, 'hF5);
    rd('h200, 'h5, "R10 stall write");
    wr('h220, 'h3);
    rd('h220, 'h1, "R10 coherency write");
    rd('h3FF, 0, "R11 unmapped high");
    rd('h104, 0, "R11 cause slot beyond cores");
    rd('h010, 0, "R11 route slot beyond lines");
    for (int i = 0; i < 2000; i++) begin
      int pick;
      int addrs [16] = '{0, 3, 7, 'h100, 'h102, 'h103, 'h140, 'h14A,
                         'h180, 'h184, 'h188, 'h18C, 'h190, 'h200, 'h220, 'h1A0};
      @(negedge clk);
      pick = $urandom_range(0, 15);
      reg_addr  = 10'(addrs[pick]);
      reg_wdata = $urandom;
      reg_we    = ($urandom_range(0, 2) == 0);
      irq_lines = NL'($urandom);
    end
    @(negedge clk); reg_we = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule